// File: doc/BRIEF.md
# Dual-Retire In-Order Completion Queue

This block tracks instructions from dispatch to retirement so that results become architectural strictly in program order, even though execution units may finish them in any order. Dispatch places up to two instructions per cycle at the tail of a circular queue and receives the slot index of each one. Execution units later report completion by that index. A completion report may carry an exception flag or a branch-mispredict flag. The queue does not act on a flag when it arrives. It acts on the flag only when the flagged entry reaches the head.

Each cycle, up to two finished entries at the head retire, oldest first. A flagged entry retires as the last instruction of its cycle. In that same cycle the queue raises a redirect that names the flagged slot and gives its cause, and every younger entry is discarded. One cycle after any retirement, the block repeats the retired count and destination tags on a write-back port, where the register file commits them.

Top module: `inorder_retire_queue`

## Requirements
- R1: After synchronous active-high reset the queue holds no entries (`occ` = 0). `ret_cnt`, `wb_cnt` and `redir_vld` are 0.
- R2: `disp_n` is the number of instructions offered this cycle (0, 1 or 2). An accepted request allocates slot `disp_idx0` = tail for the older instruction and slot `disp_idx1` = tail+1 (mod DEPTH) for the second. `occ` grows by `disp_n`.
- R3: A request is refused as a whole (`disp_ok` = 0, nothing allocated) when `disp_n` exceeds DEPTH minus `occ`, counted before this cycle's retirement. The value `disp_n` = 3 is always refused.
- R4: A finish notification on lane k (`fin_vld[k]`, `fin_idx*`, `fin_exc[k]`, `fin_mis[k]`) marks that slot finished. A notification naming a slot that holds no instruction has no effect on a later instruction placed in that slot.
- R5: Up to two entries retire per cycle, in order. `ret_dst0` is the oldest. The second entry retires only if the first does. A lane that does not retire shows tag 0.
- R6: While the head entry is unfinished nothing retires, even if younger entries are finished.
- R7: A flagged entry at the head retires alone as the last of the cycle, and in that cycle `redir_vld` = 1 and `redir_idx` = its slot. `redir_mis` = 1 means mispredict and 0 means exception. When both flags are set, the exception wins (`redir_mis` = 0).
- R8: When the second head entry is flagged and the first is a clean finished entry, both retire (`ret_cnt` = 2) and `redir_idx` names the second.
- R9: After a redirect cycle the queue is empty, and the next allocation starts at the slot just after the last retired entry. Younger entries never retire. Dispatch is refused during the redirect cycle.
- R10: `wb_cnt`, `wb_dst0` and `wb_dst1` equal `ret_cnt`, `ret_dst0` and `ret_dst1` of the previous cycle.
- R11: A flag on an entry that is not yet at the head raises no redirect and retires nothing early.
- R12: Slot indices wrap from DEPTH-1 to 0, both for the tail and for the second dispatch lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_n | input | 2 | Number of instructions offered for dispatch |
| disp_dst0 | input | TAG_W | Destination tag of the older dispatched instruction |
| disp_dst1 | input | TAG_W | Destination tag of the younger dispatched instruction |
| disp_ok | output | 1 | Dispatch request accepted this cycle |
| disp_idx0 | output | IDX_W | Slot given to the older instruction |
| disp_idx1 | output | IDX_W | Slot given to the younger instruction |
| fin_vld | input | 2 | Finish notification valid, one bit per lane |
| fin_idx0 | input | IDX_W | Slot finished on lane 0 |
| fin_idx1 | input | IDX_W | Slot finished on lane 1 |
| fin_exc | input | 2 | Exception flag per lane |
| fin_mis | input | 2 | Mispredict flag per lane |
| ret_cnt | output | 2 | Entries retiring this cycle |
| ret_dst0 | output | TAG_W | Tag of the oldest retiring entry |
| ret_dst1 | output | TAG_W | Tag of the second retiring entry |
| wb_cnt | output | 2 | Write-back count, one cycle after retirement |
| wb_dst0 | output | TAG_W | Write-back tag, lane 0 |
| wb_dst1 | output | TAG_W | Write-back tag, lane 1 |
| redir_vld | output | 1 | Flush and refetch request |
| redir_idx | output | IDX_W | Slot of the flagged entry causing the redirect |
| redir_mis | output | 1 | Redirect cause: 1 mispredict, 0 exception |
| occ | output | CNT_W | Number of entries in the queue |

## Verification
The embedded properties rely on the finish lanes naming slots below DEPTH and on the environment reporting each instruction through the index it received from dispatch. Under those conditions the valid-bit count, the occupancy and the retire flow stay consistent with one another. The bench only finishes slots it recorded from `disp_idx0` and `disp_idx1`, or the free slot it targets on purpose for R4, so every index it drives is in range. It reports each entry once, applies both flags only to the head entry in the exception-priority case, and holds reset for several cycles before any stimulus.

// File: rtl/roq_pkg.sv
package roq_pkg;
   // Per-slot state bits
   typedef struct packed {
      logic vld;
      logic fin;
      logic exc;
      logic mis;
   } roq_flags_t;

   localparam int unsigned ROQ_LANES = 2;
endpackage

// File: rtl/roq_store.sv
module roq_store
   import roq_pkg::*;
#(
   parameter int DEPTH = 14,
   parameter int TAG_W = 5,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             flush_all,
   input  logic [1:0]       alloc_en,
   input  logic [IDX_W-1:0] alloc_idx0,
   input  logic [IDX_W-1:0] alloc_idx1,
   input  logic [TAG_W-1:0] alloc_dst0,
   input  logic [TAG_W-1:0] alloc_dst1,
   input  logic [1:0]       fin_vld,
   input  logic [IDX_W-1:0] fin_idx0,
   input  logic [IDX_W-1:0] fin_idx1,
   input  logic [1:0]       fin_exc,
   input  logic [1:0]       fin_mis,
   input  logic [1:0]       clr_en,
   input  logic [IDX_W-1:0] clr_idx0,
   input  logic [IDX_W-1:0] clr_idx1,
   output roq_flags_t       flags [DEPTH],
   output logic [TAG_W-1:0] dsts  [DEPTH],
   output logic [DEPTH-1:0] vld_vec
);
   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      localparam logic [IDX_W-1:0] MY = IDX_W'(e);
      roq_flags_t       ent_q;
      logic [TAG_W-1:0] dst_q;
      logic a0, a1, f0, f1, c0;

      assign a0 = alloc_en[0] && (alloc_idx0 == MY);
      assign a1 = alloc_en[1] && (alloc_idx1 == MY);
      assign f0 = fin_vld[0] && (fin_idx0 == MY);
      assign f1 = fin_vld[1] && (fin_idx1 == MY);
      assign c0 = (clr_en[0] && (clr_idx0 == MY)) || (clr_en[1] && (clr_idx1 == MY));

      always_ff @(posedge clk) begin
         if (rst || flush_all) begin
            ent_q <= '0;
         end else if (a0 || a1) begin
            ent_q <= '{vld: 1'b1, fin: 1'b0, exc: 1'b0, mis: 1'b0};
         end else if (ent_q.vld) begin
            if (c0) begin
               ent_q.vld <= 1'b0;
            end else if (f0 || f1) begin
               ent_q.fin <= 1'b1;
               ent_q.exc <= ent_q.exc | (f0 & fin_exc[0]) | (f1 & fin_exc[1]);
               ent_q.mis <= ent_q.mis | (f0 & fin_mis[0]) | (f1 & fin_mis[1]);
            end
         end
      end

      always_ff @(posedge clk) begin
         if (a0)      dst_q <= alloc_dst0;
         else if (a1) dst_q <= alloc_dst1;
      end

      assign flags[e]   = ent_q;
      assign dsts[e]    = dst_q;
      assign vld_vec[e] = ent_q.vld;
   end

   // A flush leaves no live slot behind
   assert_flush_clears_R9 : assert property (@(posedge clk) disable iff (rst)
      flush_all |=> (vld_vec == '0));
endmodule

// File: rtl/roq_ptrs.sv
module roq_ptrs #(
   parameter int DEPTH = 14,
   parameter int IDX_W = $clog2(DEPTH),
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       disp_n,
   input  logic [1:0]       ret_cnt,
   input  logic             flush_now,
   output logic             disp_ok,
   output logic [1:0]       alloc_en,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] head1,
   output logic [IDX_W-1:0] tail,
   output logic [IDX_W-1:0] tail1,
   output logic [CNT_W-1:0] occ
);
   localparam logic [IDX_W:0] DEPTH_X = (IDX_W + 1)'(DEPTH);
   localparam logic [CNT_W:0] DEPTH_C = (CNT_W + 1)'(DEPTH);

   function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] p,
                                                 input logic [1:0] n);
      logic [IDX_W:0] s;
      s = {1'b0, p} + {{(IDX_W - 1){1'b0}}, n};
      if (s >= DEPTH_X) s = s - DEPTH_X;
      return s[IDX_W-1:0];
   endfunction

   logic [IDX_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] occ_q;
   logic [CNT_W:0]   free_w, need_w;
   logic [1:0]       acc_n;
   logic [IDX_W-1:0] head_nx;

   assign free_w  = DEPTH_C - {1'b0, occ_q};
   assign need_w  = {{(CNT_W - 1){1'b0}}, disp_n};
   assign disp_ok = (disp_n != 2'd3) && (need_w <= free_w) && !flush_now;
   assign acc_n   = disp_ok ? disp_n : 2'd0;
   assign alloc_en = {acc_n == 2'd2, acc_n != 2'd0};
   assign head_nx = wrap_add(head_q, ret_cnt);

   always_ff @(posedge clk) begin
      if (rst) begin
         head_q <= '0;
         tail_q <= '0;
         occ_q  <= '0;
      end else if (flush_now) begin
         head_q <= head_nx;
         tail_q <= head_nx;
         occ_q  <= '0;
      end else begin
         head_q <= head_nx;
         tail_q <= wrap_add(tail_q, acc_n);
         occ_q  <= occ_q + CNT_W'(acc_n) - CNT_W'(ret_cnt);
      end
   end

   assign head  = head_q;
   assign head1 = wrap_add(head_q, 2'd1);
   assign tail  = tail_q;
   assign tail1 = wrap_add(tail_q, 2'd1);
   assign occ   = occ_q;

   assert_no_overflow_R3 : assert property (@(posedge clk) disable iff (rst)
      occ_q <= CNT_W'(DEPTH));
   assert_flush_resets_ptrs_R9 : assert property (@(posedge clk) disable iff (rst)
      flush_now |=> (tail_q == head_q) && (occ_q == '0));
   assert_retire_bounded_R5 : assert property (@(posedge clk) disable iff (rst)
      {1'b0, ret_cnt} <= occ_q[CNT_W-1:0] + 3'd0);
endmodule

// File: rtl/roq_retire_sel.sv
module roq_retire_sel
   import roq_pkg::*;
#(
   parameter int DEPTH = 14,
   parameter int TAG_W = 5,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  roq_flags_t       flags [DEPTH],
   input  logic [TAG_W-1:0] dsts  [DEPTH],
   input  logic [IDX_W-1:0] head,
   input  logic [IDX_W-1:0] head1,
   output logic [1:0]       ret_cnt,
   output logic [TAG_W-1:0] ret_dst0,
   output logic [TAG_W-1:0] ret_dst1,
   output logic [1:0]       clr_en,
   output logic             flush_now,
   output logic [IDX_W-1:0] redir_idx,
   output logic             redir_mis
);
   roq_flags_t e0, e1;
   logic r0, r1, flag0, flag1, take0;

   assign e0    = flags[head];
   assign e1    = flags[head1];
   assign flag0 = e0.exc | e0.mis;
   assign flag1 = e1.exc | e1.mis;
   assign r0    = e0.vld & e0.fin;
   assign r1    = r0 & ~flag0 & e1.vld & e1.fin;
   assign take0 = r0 & flag0;

   assign ret_cnt   = {1'b0, r0} + {1'b0, r1};
   assign ret_dst0  = r0 ? dsts[head]  : '0;
   assign ret_dst1  = r1 ? dsts[head1] : '0;
   assign clr_en    = {r1, r0};
   assign flush_now = take0 | (r1 & flag1);
   assign redir_idx = take0 ? head : head1;
   assign redir_mis = take0 ? (e0.mis & ~e0.exc) : (e1.mis & ~e1.exc);

   assert_redirect_at_head_R7 : assert property (@(posedge clk) disable iff (rst)
      flush_now |-> ((redir_idx == head) || (redir_idx == head1)));
   assert_pair_in_order_R5 : assert property (@(posedge clk) disable iff (rst)
      (ret_cnt == 2'd2) |-> (ret_dst0 == dsts[head]) && (ret_cnt != 2'd3));
endmodule

// File: rtl/inorder_retire_queue.sv
module inorder_retire_queue
   import roq_pkg::*;
#(
   parameter int DEPTH = 14,
   parameter int TAG_W = 5,
   parameter int IDX_W = $clog2(DEPTH),
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       disp_n,
   input  logic [TAG_W-1:0] disp_dst0,
   input  logic [TAG_W-1:0] disp_dst1,
   output logic             disp_ok,
   output logic [IDX_W-1:0] disp_idx0,
   output logic [IDX_W-1:0] disp_idx1,
   input  logic [1:0]       fin_vld,
   input  logic [IDX_W-1:0] fin_idx0,
   input  logic [IDX_W-1:0] fin_idx1,
   input  logic [1:0]       fin_exc,
   input  logic [1:0]       fin_mis,
   output logic [1:0]       ret_cnt,
   output logic [TAG_W-1:0] ret_dst0,
   output logic [TAG_W-1:0] ret_dst1,
   output logic [1:0]       wb_cnt,
   output logic [TAG_W-1:0] wb_dst0,
   output logic [TAG_W-1:0] wb_dst1,
   output logic             redir_vld,
   output logic [IDX_W-1:0] redir_idx,
   output logic             redir_mis,
   output logic [CNT_W-1:0] occ
);
   // Elaboration-time parameter checks
   if (DEPTH < 4) begin : g_bad_depth
      $error("inorder_retire_queue: DEPTH must be at least 4");
   end
   if ((1 << IDX_W) < DEPTH) begin : g_bad_idx
      $error("inorder_retire_queue: IDX_W too narrow for DEPTH");
   end
   if ((1 << CNT_W) <= DEPTH) begin : g_bad_cnt
      $error("inorder_retire_queue: CNT_W too narrow for DEPTH");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("inorder_retire_queue: TAG_W must be positive");
   end

   roq_flags_t       flags [DEPTH];
   logic [TAG_W-1:0] dsts  [DEPTH];
   logic [DEPTH-1:0] vld_vec;
   logic [1:0]       alloc_en, clr_en;
   logic [IDX_W-1:0] head, head1;
   logic             flush_now;
   logic [1:0]       wb_cnt_q;
   logic [TAG_W-1:0] wb_dst0_q, wb_dst1_q;

   roq_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptrs (
      .clk(clk), .rst(rst), .disp_n(disp_n), .ret_cnt(ret_cnt),
      .flush_now(flush_now), .disp_ok(disp_ok), .alloc_en(alloc_en),
      .head(head), .head1(head1), .tail(disp_idx0), .tail1(disp_idx1),
      .occ(occ)
   );

   roq_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_store (
      .clk(clk), .rst(rst), .flush_all(flush_now), .alloc_en(alloc_en),
      .alloc_idx0(disp_idx0), .alloc_idx1(disp_idx1),
      .alloc_dst0(disp_dst0), .alloc_dst1(disp_dst1),
      .fin_vld(fin_vld), .fin_idx0(fin_idx0), .fin_idx1(fin_idx1),
      .fin_exc(fin_exc), .fin_mis(fin_mis),
      .clr_en(clr_en), .clr_idx0(head), .clr_idx1(head1),
      .flags(flags), .dsts(dsts), .vld_vec(vld_vec)
   );

   roq_retire_sel #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_sel (
      .clk(clk), .rst(rst), .flags(flags), .dsts(dsts),
      .head(head), .head1(head1), .ret_cnt(ret_cnt),
      .ret_dst0(ret_dst0), .ret_dst1(ret_dst1), .clr_en(clr_en),
      .flush_now(flush_now), .redir_idx(redir_idx), .redir_mis(redir_mis)
   );

   assign redir_vld = flush_now;

   // Write-back stage: one register behind retirement
   always_ff @(posedge clk) begin
      if (rst) begin
         wb_cnt_q  <= '0;
         wb_dst0_q <= '0;
         wb_dst1_q <= '0;
      end else begin
         wb_cnt_q  <= ret_cnt;
         wb_dst0_q <= ret_dst0;
         wb_dst1_q <= ret_dst1;
      end
   end

   assign wb_cnt  = wb_cnt_q;
   assign wb_dst0 = wb_dst0_q;
   assign wb_dst1 = wb_dst1_q;

   assert_wb_delay_R10 : assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (wb_cnt == $past(ret_cnt)) && (wb_dst0 == $past(ret_dst0)));
   assert_head_finished_R6 : assert property (@(posedge clk) disable iff (rst)
      (ret_cnt != 2'd0) |-> flags[head].fin);
   assert_occ_matches_slots_R2 : assert property (@(posedge clk) disable iff (rst)
      $countones(vld_vec) == int'(occ));
   assert_no_disp_on_redirect_R9 : assert property (@(posedge clk) disable iff (rst)
      redir_vld |=> (occ == '0));
endmodule

// File: tb/inorder_retire_queue_bench.sv
`timescale 1ns/1ps
module inorder_retire_queue_bench;
   localparam int DEPTH = 14;
   localparam int TAG_W = 5;
   localparam int IDX_W = 4;
   localparam int CNT_W = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic             rst;
   logic [1:0]       disp_n;
   logic [TAG_W-1:0] disp_dst0, disp_dst1;
   logic             disp_ok;
   logic [IDX_W-1:0] disp_idx0, disp_idx1;
   logic [1:0]       fin_vld, fin_exc, fin_mis;
   logic [IDX_W-1:0] fin_idx0, fin_idx1;
   logic [1:0]       ret_cnt, wb_cnt;
   logic [TAG_W-1:0] ret_dst0, ret_dst1, wb_dst0, wb_dst1;
   logic             redir_vld, redir_mis;
   logic [IDX_W-1:0] redir_idx;
   logic [CNT_W-1:0] occ;

   inorder_retire_queue u_inorder_retire_queue (
      .clk(clk), .rst(rst), .disp_n(disp_n), .disp_dst0(disp_dst0),
      .disp_dst1(disp_dst1), .disp_ok(disp_ok), .disp_idx0(disp_idx0),
      .disp_idx1(disp_idx1), .fin_vld(fin_vld), .fin_idx0(fin_idx0),
      .fin_idx1(fin_idx1), .fin_exc(fin_exc), .fin_mis(fin_mis),
      .ret_cnt(ret_cnt), .ret_dst0(ret_dst0), .ret_dst1(ret_dst1),
      .wb_cnt(wb_cnt), .wb_dst0(wb_dst0), .wb_dst1(wb_dst1),
      .redir_vld(redir_vld), .redir_idx(redir_idx), .redir_mis(redir_mis),
      .occ(occ)
   );

   int n_run = 0;
   int n_fail = 0;
   int m_head = 0, m_tail = 0, m_occ = 0;
   int m_dst [DEPTH];

   function automatic int wrapf(int p, int n);
      return (p + n) % DEPTH;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle();
      disp_n = '0; disp_dst0 = '0; disp_dst1 = '0;
      fin_vld = '0; fin_idx0 = '0; fin_idx1 = '0; fin_exc = '0; fin_mis = '0;
   endtask

   task automatic begin_cyc();
      @(negedge clk); #1;
   endtask

   task automatic end_cyc();
      @(posedge clk); #1;
      idle();
   endtask

   task automatic dispatch(int n, int d0, int d1, bit exp_ok);
      begin_cyc();
      disp_n = 2'(n); disp_dst0 = TAG_W'(d0); disp_dst1 = TAG_W'(d1);
      #1;
      chk("R3", "disp_ok", int'(disp_ok), int'(exp_ok));
      if (exp_ok && n > 0) begin
         chk("R2", "disp_idx0", int'(disp_idx0), m_tail);
         m_dst[m_tail] = d0;
         if (n == 2) begin
            chk("R12", "disp_idx1", int'(disp_idx1), wrapf(m_tail, 1));
            m_dst[wrapf(m_tail, 1)] = d1;
         end
         m_tail = wrapf(m_tail, n);
         m_occ += n;
      end
      end_cyc();
   endtask

   task automatic finish(logic [1:0] v, int i0, bit e0, bit mi0, int i1, bit e1, bit mi1);
      begin_cyc();
      fin_vld = v;
      fin_idx0 = IDX_W'(i0); fin_idx1 = IDX_W'(i1);
      fin_exc = {e1, e0}; fin_mis = {mi1, mi0};
      end_cyc();
   endtask

   // Observes the current cycle; the caller closes it with end_cyc
   task automatic expect_ret(string req, int cnt, int d0, int d1, bit rd, int ridx, bit rmis);
      begin_cyc();
      chk(req, "occ", int'(occ), m_occ);
      chk(req, "ret_cnt", int'(ret_cnt), cnt);
      chk(req, "ret_dst0", int'(ret_dst0), d0);
      chk(req, "ret_dst1", int'(ret_dst1), d1);
      chk(req, "redir_vld", int'(redir_vld), int'(rd));
      if (rd) begin
         chk(req, "redir_idx", int'(redir_idx), ridx);
         chk(req, "redir_mis", int'(redir_mis), int'(rmis));
      end
      m_head = wrapf(m_head, cnt);
      m_occ -= cnt;
      if (rd) begin
         m_tail = m_head;
         m_occ = 0;
      end
   endtask

   task automatic expect_wb(int cnt, int d0, int d1);
      begin_cyc();
      chk("R10", "wb_cnt", int'(wb_cnt), cnt);
      chk("R10", "wb_dst0", int'(wb_dst0), d0);
      chk("R10", "wb_dst1", int'(wb_dst1), d1);
      end_cyc();
   endtask

   // Finishes head entries two at a time and checks ordered retirement
   task automatic drain();
      for (int guard = 0; guard < 10 && m_occ > 0; guard++) begin
         int k, d0, d1;
         k = (m_occ >= 2) ? 2 : 1;
         d0 = m_dst[m_head];
         d1 = (k == 2) ? m_dst[wrapf(m_head, 1)] : 0;
         finish((k == 2) ? 2'b11 : 2'b01, m_head, 0, 0, wrapf(m_head, 1), 0, 0);
         expect_ret("R5", k, d0, d1, 0, 0, 0);
         end_cyc();
         expect_wb(k, d0, d1);
      end
   endtask

   task automatic t_reset();
      begin_cyc();
      chk("R1", "occ", int'(occ), 0);
      chk("R1", "ret_cnt", int'(ret_cnt), 0);
      chk("R1", "wb_cnt", int'(wb_cnt), 0);
      chk("R1", "redir_vld", int'(redir_vld), 0);
      end_cyc();
   endtask

   task automatic t_basic();
      dispatch(2, 1, 2, 1);
      dispatch(1, 3, 0, 1);
      finish(2'b01, 1, 0, 0, 0, 0, 0);
      expect_ret("R6", 0, 0, 0, 0, 0, 0); end_cyc();
      finish(2'b01, 0, 0, 0, 0, 0, 0);
      expect_ret("R5", 2, 1, 2, 0, 0, 0); end_cyc();
      expect_wb(2, 1, 2);
      expect_ret("R6", 0, 0, 0, 0, 0, 0); end_cyc();
      finish(2'b01, 2, 0, 0, 0, 0, 0);
      expect_ret("R5", 1, 3, 0, 0, 0, 0); end_cyc();
      // Slot 3 is free here; the notice must not stick to a later occupant
      finish(2'b01, 3, 0, 0, 0, 0, 0);
      dispatch(1, 7, 0, 1);
      expect_ret("R4", 0, 0, 0, 0, 0, 0); end_cyc();
      drain();
   endtask

   task automatic t_full_wrap();
      dispatch(1, 9, 0, 1);
      for (int k = 0; k < 6; k++) dispatch(2, 10 + 2 * k, 11 + 2 * k, 1);
      dispatch(2, 1, 1, 0);
      begin_cyc(); chk("R3", "occ after refused pair", int'(occ), 13); end_cyc();
      dispatch(1, 23, 0, 1);
      dispatch(1, 25, 0, 0);
      begin_cyc(); chk("R3", "occ when full", int'(occ), 14); end_cyc();
      drain();
   endtask

   task automatic t_exc_second();
      dispatch(2, 20, 21, 1);
      dispatch(2, 22, 23, 1);
      finish(2'b11, 5, 1, 0, 6, 0, 0);
      expect_ret("R11", 0, 0, 0, 0, 0, 0); end_cyc();
      finish(2'b01, 7, 0, 0, 0, 0, 0);
      expect_ret("R11", 0, 0, 0, 0, 0, 0); end_cyc();
      finish(2'b01, 4, 0, 0, 0, 0, 0);
      expect_ret("R8", 2, 20, 21, 1, 5, 0);
      disp_n = 2'd1; disp_dst0 = 5'd9;
      #1;
      chk("R9", "disp_ok during redirect", int'(disp_ok), 0);
      end_cyc();
      expect_wb(2, 20, 21);
      expect_ret("R9", 0, 0, 0, 0, 0, 0); end_cyc();
      chk("R9", "model tail after flush", m_tail, 6);
      dispatch(1, 5, 0, 1);
      drain();
   endtask

   task automatic t_mis_head();
      dispatch(2, 30, 31, 1);
      finish(2'b11, 7, 0, 1, 8, 0, 0);
      expect_ret("R7", 1, 30, 0, 1, 7, 1); end_cyc();
      expect_ret("R9", 0, 0, 0, 0, 0, 0); end_cyc();
      // Both flags on one head entry: exception takes precedence
      dispatch(1, 12, 0, 1);
      finish(2'b01, 8, 1, 1, 0, 0, 0);
      expect_ret("R7", 1, 12, 0, 1, 8, 0); end_cyc();
      dispatch(3, 1, 2, 0);
      expect_ret("R3", 0, 0, 0, 0, 0, 0); end_cyc();
   endtask

   initial begin
      idle();
      rst = 1'b1;
      repeat (4) @(posedge clk);
      #1 rst = 1'b0;
      t_reset();
      t_basic();
      t_full_wrap();
      t_exc_second();
      t_mis_head();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(20 * 100000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog (all R): actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule